// File: doc/BRIEF.md
# Pipelined Separating Neuron with On-Line Weight Learning

This block is one output neuron of a single-layer network that separates linear mixtures of independent signals. Sample vectors are first written into a local sample memory. A start pulse then replays those samples in address order through a four-stage pipeline: weight fetch, synaptic input (dot product of the weight row with the sample), score function, and weight-change computation with write-back. A new sample enters the pipeline every cycle, so a sample's synaptic input sees only the weight changes that were complete when it was fetched. That lag is fixed and defined, not a race.

After each full pass over the samples the block compares the largest weight-change magnitude seen in that pass with a programmable threshold. If the largest change is below the threshold, the weights are declared converged. A cap on the number of passes ends learning when they are not. The neuron then makes one output pass, emitting the separated component for every stored sample with the final weights, and returns to idle. The score function sits in its own one-cycle submodule selected by a parameter, so another odd nonlinearity can replace it without retiming the pipeline. The learned weight row is visible at all times on an output port.

Top module: `sepn_neuron`

## Requirements
- R1: After reset, busy, done, conv_ok, y_valid and passes are 0, and wgt_o holds the identity row: lane ROW (default 0) equals 16384 (1.0 in Q2.14) and every other lane is 0.
- R2: While the block is idle, a cycle with smp_we high stores smp_data at smp_addr. Lane j of a vector occupies bits [16j+15:16j] as signed Q2.14. A write while busy is dropped and leaves the stored sample unchanged.
- R3: A start pulse while idle reloads the identity row and clears done, conv_ok and passes. busy is high from the following cycle. A start pulse while busy is ignored.
- R4: The synaptic input is the sum over lanes of w_j*x_j, shifted right arithmetically by 14 (rounding toward minus infinity) and saturated to signed 16 bits.
- R5: The default score is phi(u)=u. For each lane the weight change is d_j = (E_j - floor(phi*x_j / 2^14)) >>> MU_SHIFT (MU_SHIFT = 4), where E_j is 16384 for lane ROW and 0 otherwise. The new weight is w_j + d_j, saturated to signed 16 bits.
- R6: Within a pass, sample k uses weights that include the changes from samples 0..k-3 of that pass and none later. Samples 0, 1 and 2 use the weights held at the start of the pass.
- R7: Each learning pass takes samples 0..NSMP-1 in address order. After the pass, if the largest |d_j| over the pass is strictly below conv_thresh (an unsigned value held steady during a run), learning stops with conv_ok = 1.
- R8: passes counts completed learning passes. When it reaches MAX_PASSES (16) without meeting the threshold, learning stops with conv_ok = 0. passes never exceeds MAX_PASSES and never steps by more than one.
- R9: After learning, y_valid is high for NSMP consecutive cycles. y_data carries the synaptic input (R4 rule) of samples 0..NSMP-1 in order, using the final weights. In the cycle after the last output, busy is 0 and done is 1.
- R10: wgt_o shows the current weights. While idle and without start, wgt_o, passes, conv_ok and done hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_we | input | 1 | Sample memory write enable (idle only) |
| smp_addr | input | AW = 3 | Sample memory write address |
| smp_data | input | 64 | Sample vector, four signed Q2.14 lanes |
| start | input | 1 | Begin learning (idle only) |
| conv_thresh | input | 16 | Unsigned convergence threshold on weight change |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished |
| conv_ok | output | 1 | Last run met the threshold |
| passes | output | 5 | Completed learning passes |
| y_valid | output | 1 | y_data carries a separated sample |
| y_data | output | 16 | Separated output, signed Q2.14 |
| wgt_o | output | 64 | Current weight row, four signed Q2.14 lanes |

## Verification
The weight write-back of the update stage and the weight fetch for a newer sample fall in the same cycle whenever a sample sits three places behind another in a pass. This happens on every sample from the fourth onward, so every run provokes it. The bench's reference model replays each pass in plain integer arithmetic under the three-sample lag rule. It compares every separated output clock by clock and the final weight row lane by lane, so a fetch that missed the same-cycle write shows up as a mismatch. A second collision, a sample write and a start pulse landing mid-run, is provoked on a multi-pass run. It is judged by identical results on that run and on a later run over the same stored samples.

// File: rtl/sepn_pkg.sv
package sepn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEARN,
    ST_LDRAIN,
    ST_SEP,
    ST_SDRAIN
  } sepn_state_e;
endpackage

// File: rtl/sepn_smp_ram.sv
module sepn_smp_ram #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sepn_score.sv
module sepn_score #(
  parameter int DW   = 16,
  parameter int FRAC = 14,
  parameter int KIND = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] u_i,
  output logic signed [DW-1:0] phi_o
);
  localparam int MAXV = 2 ** (DW - 1) - 1;
  localparam int MINV = -(2 ** (DW - 1));
  logic signed [DW-1:0] f;

  generate
    if (KIND == 0) begin : g_lin
      always_comb f = u_i;
    end else begin : g_cube
      localparam int CW = 3 * DW;
      logic signed [CW-1:0] cube;
      logic signed [CW-1:0] sh;
      always_comb begin
        cube = CW'(u_i) * CW'(u_i) * CW'(u_i);
        sh   = cube >>> (2 * FRAC);
        if (sh > CW'(MAXV))      f = DW'(MAXV);
        else if (sh < CW'(MINV)) f = DW'(MINV);
        else                     f = sh[DW-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) phi_o <= '0;
    else     phi_o <= f;
  end
endmodule

// File: rtl/sepn_update.sv
module sepn_update #(
  parameter int N_IN     = 4,
  parameter int DW       = 16,
  parameter int FRAC     = 14,
  parameter int MU_SHIFT = 4,
  parameter int ROW      = 0,
  localparam int VW = N_IN * DW,
  localparam int PW = 2 * DW + 1
) (
  input  logic [VW-1:0]        w_i,
  input  logic [VW-1:0]        x_i,
  input  logic signed [DW-1:0] phi_i,
  output logic [VW-1:0]        w_o,
  output logic [PW-1:0]        dmax_o
);
  localparam int MAXV = 2 ** (DW - 1) - 1;
  localparam int MINV = -(2 ** (DW - 1));

  function automatic logic [DW-1:0] clip(input logic signed [PW-1:0] v);
    if (v > PW'(MAXV))      return DW'(MAXV);
    else if (v < PW'(MINV)) return DW'(MINV);
    else                    return v[DW-1:0];
  endfunction

  logic [PW-1:0] mag [N_IN];

  generate
    for (genvar j = 0; j < N_IN; j++) begin : g_lane
      localparam int EV = (j == ROW) ? (1 << FRAC) : 0;
      logic signed [PW-1:0] prod, e, d, s;
      logic [DW-1:0] wn;
      logic [PW-1:0] m;
      always_comb begin
        prod = PW'(phi_i) * PW'($signed(x_i[j*DW +: DW]));
        e    = PW'(EV) - (prod >>> FRAC);
        d    = e >>> MU_SHIFT;
        s    = PW'($signed(w_i[j*DW +: DW])) + d;
        wn   = clip(s);
        m    = d[PW-1] ? PW'(-d) : PW'(d);
      end
      assign w_o[j*DW +: DW] = wn;
      assign mag[j] = m;
    end
  endgenerate

  always_comb begin
    dmax_o = '0;
    for (int j = 0; j < N_IN; j++)
      if (mag[j] > dmax_o) dmax_o = mag[j];
  end
endmodule

// File: rtl/sepn_neuron.sv
module sepn_neuron
  import sepn_pkg::*;
#(
  parameter int N_IN       = 4,
  parameter int DW         = 16,
  parameter int FRAC       = 14,
  parameter int NSMP       = 8,
  parameter int MU_SHIFT   = 4,
  parameter int MAX_PASSES = 16,
  parameter int ROW        = 0,
  parameter int SCORE_KIND = 0,
  localparam int AW  = $clog2(NSMP),
  localparam int PCW = $clog2(MAX_PASSES + 1),
  localparam int VW  = N_IN * DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_we,
  input  logic [AW-1:0]  smp_addr,
  input  logic [VW-1:0]  smp_data,
  input  logic           start,
  input  logic [DW-1:0]  conv_thresh,
  output logic           busy,
  output logic           done,
  output logic           conv_ok,
  output logic [PCW-1:0] passes,
  output logic           y_valid,
  output logic [DW-1:0]  y_data,
  output logic [VW-1:0]  wgt_o
);
  localparam int ACCW = 2 * DW + $clog2(N_IN) + 1;
  localparam int PW   = 2 * DW + 1;
  localparam int MAXV = 2 ** (DW - 1) - 1;
  localparam int MINV = -(2 ** (DW - 1));
  localparam logic [VW-1:0] W_INIT = {{(VW-DW){1'b0}}, DW'(1 << FRAC)} << (ROW * DW);

  function automatic logic [DW-1:0] clip_acc(input logic signed [ACCW-1:0] v);
    if (v > ACCW'(MAXV))      return DW'(MAXV);
    else if (v < ACCW'(MINV)) return DW'(MINV);
    else                      return v[DW-1:0];
  endfunction

  sepn_state_e st;
  logic [AW-1:0] k;
  logic issue, issue_lrn, upd;
  logic [VW-1:0] w_reg, w_nxt, w_s1, x_s1, x_s2, x_s3;
  logic s1_v, s2_v, s3_v, s1_l, s2_l, s3_l;
  logic signed [ACCW-1:0] acc;
  logic signed [DW-1:0] u_now, u_s2, phi_s3;
  logic [PW-1:0] dmax, pmax;

  assign issue     = (st == ST_LEARN) || (st == ST_SEP);
  assign issue_lrn = (st == ST_LEARN);
  assign upd       = s3_v && s3_l;
  assign wgt_o     = w_reg;

  // stage 1: sample fetch alongside weight snapshot
  sepn_smp_ram #(.WIDTH(VW), .DEPTH(NSMP)) u_smp (
    .clk  (clk),
    .we   (smp_we && (st == ST_IDLE)),
    .waddr(smp_addr),
    .wdata(smp_data),
    .re   (issue),
    .raddr(k),
    .rdata(x_s1)
  );

  // stage 2: synaptic input
  always_comb begin
    acc = '0;
    for (int j = 0; j < N_IN; j++)
      acc += ACCW'($signed(w_s1[j*DW +: DW])) * ACCW'($signed(x_s1[j*DW +: DW]));
    u_now = clip_acc(acc >>> FRAC);
  end

  // stage 3: score function
  sepn_score #(.DW(DW), .FRAC(FRAC), .KIND(SCORE_KIND)) u_score (
    .clk  (clk),
    .rst  (rst),
    .u_i  (u_s2),
    .phi_o(phi_s3)
  );

  // stage 4: weight change
  sepn_update #(.N_IN(N_IN), .DW(DW), .FRAC(FRAC), .MU_SHIFT(MU_SHIFT), .ROW(ROW)) u_upd (
    .w_i   (w_reg),
    .x_i   (x_s3),
    .phi_i (phi_s3),
    .w_o   (w_nxt),
    .dmax_o(dmax)
  );

  always_ff @(posedge clk) begin
    s1_l <= issue_lrn;
    s2_l <= s1_l;
    s3_l <= s2_l;
    // same-cycle bypass of the write-back into the snapshot
    w_s1 <= upd ? w_nxt : w_reg;
    u_s2 <= u_now;
    x_s2 <= x_s1;
    x_s3 <= x_s2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s2_v    <= 1'b0;
      s3_v    <= 1'b0;
      y_valid <= 1'b0;
      y_data  <= '0;
    end else begin
      s1_v    <= issue;
      s2_v    <= s1_v;
      s3_v    <= s2_v;
      y_valid <= s1_v && !s1_l;
      if (s1_v && !s1_l) y_data <= u_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      k       <= '0;
      w_reg   <= W_INIT;
      pmax    <= '0;
      passes  <= '0;
      conv_ok <= 1'b0;
      done    <= 1'b0;
      busy    <= 1'b0;
    end else begin
      if (upd) begin
        w_reg <= w_nxt;
        if (dmax > pmax) pmax <= dmax;
      end
      unique case (st)
        ST_IDLE: if (start) begin
          w_reg   <= W_INIT;
          pmax    <= '0;
          passes  <= '0;
          conv_ok <= 1'b0;
          done    <= 1'b0;
          busy    <= 1'b1;
          k       <= '0;
          st      <= ST_LEARN;
        end
        ST_LEARN, ST_SEP: begin
          if (k == AW'(NSMP - 1)) begin
            k  <= '0;
            st <= (st == ST_LEARN) ? ST_LDRAIN : ST_SDRAIN;
          end else begin
            k <= k + 1'b1;
          end
        end
        ST_LDRAIN: if (!s1_v && !s2_v && !s3_v) begin
          passes <= passes + 1'b1;
          pmax   <= '0;
          if (pmax < {{(PW-DW){1'b0}}, conv_thresh}) begin
            conv_ok <= 1'b1;
            st      <= ST_SEP;
          end else if (passes == PCW'(MAX_PASSES - 1)) begin
            st <= ST_SEP;
          end else begin
            st <= ST_LEARN;
          end
        end
        ST_SDRAIN: if (!s1_v) begin
          st   <= ST_IDLE;
          busy <= 1'b0;
          done <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/sepn_neuron_chk.sv
module sepn_neuron_chk #(
  parameter int DW         = 16,
  parameter int VW         = 64,
  parameter int PCW        = 5,
  parameter int MAX_PASSES = 16,
  parameter logic [VW-1:0] INIT = '0
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           conv_ok,
  input logic [PCW-1:0] passes,
  input logic           y_valid,
  input logic [VW-1:0]  wgt_o
);
  assert_pass_cap_R8: assert property (@(posedge clk) disable iff (rst)
    passes <= PCW'(MAX_PASSES));

  assert_pass_step_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> (passes == $past(passes) || passes == $past(passes) + 1'b1));

  assert_launch_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && !done && !conv_ok && passes == '0 && wgt_o == INIT));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(wgt_o) && $stable(passes) && $stable(conv_ok) && $stable(done)));

  assert_out_in_run_R9: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> busy);

  assert_out_tail_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(y_valid) |-> (!busy && done));
endmodule

bind sepn_neuron sepn_neuron_chk #(
  .DW(DW), .VW(VW), .PCW(PCW), .MAX_PASSES(MAX_PASSES), .INIT(W_INIT)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .conv_ok(conv_ok),
  .passes (passes),
  .y_valid(y_valid),
  .wgt_o  (wgt_o)
);

// File: tb/sim_sepn_neuron.sv
module sim_sepn_neuron;
  localparam int N = 4, DW = 16, NS = 8, MU = 4, MAXP = 16, ROW = 0;
  localparam int AW = $clog2(NS), PCW = $clog2(MAXP + 1), VW = N * DW;

  logic clk = 1'b0, rst = 1'b1;
  logic smp_we = 1'b0, start = 1'b0;
  logic [AW-1:0] smp_addr = '0;
  logic [VW-1:0] smp_data = '0;
  logic [DW-1:0] conv_thresh = '0;
  logic busy, done, conv_ok, y_valid;
  logic [PCW-1:0] passes;
  logic [DW-1:0] y_data;
  logic [VW-1:0] wgt_o;

  always #5 clk = ~clk;

  sepn_neuron u0 (
    .clk(clk), .rst(rst), .smp_we(smp_we), .smp_addr(smp_addr), .smp_data(smp_data),
    .start(start), .conv_thresh(conv_thresh), .busy(busy), .done(done), .conv_ok(conv_ok),
    .passes(passes), .y_valid(y_valid), .y_data(y_data), .wgt_o(wgt_o)
  );

  int n_chk = 0, n_fail = 0;
  int smem [NS][N];
  int yq [$];

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int dotsat(input int w [N], input int k);
    longint acc = 0;
    for (int j = 0; j < N; j++) acc += longint'(w[j]) * longint'(smem[k][j]);
    return sat16(acc >>> 14);
  endfunction

  // behavioural reference: lagged per-sample learning, then one output pass
  task automatic model(input int th, output int ep, output bit ec, output int ew [N]);
    int w0 [N];
    int wa [NS][N];
    int wu [N];
    longint mx, pr, e, d, ad;
    int u;
    for (int j = 0; j < N; j++) w0[j] = (j == ROW) ? 16384 : 0;
    ep = 0;
    ec = 1'b0;
    while (1) begin
      mx = 0;
      for (int k = 0; k < NS; k++) begin
        for (int j = 0; j < N; j++) wu[j] = (k >= 3) ? wa[k-3][j] : w0[j];
        u = dotsat(wu, k);
        for (int j = 0; j < N; j++) begin
          pr = longint'(u) * longint'(smem[k][j]);
          e  = ((j == ROW) ? 16384 : 0) - (pr >>> 14);
          d  = e >>> MU;
          ad = (d < 0) ? -d : d;
          if (ad > mx) mx = ad;
          wa[k][j] = sat16(((k > 0) ? wa[k-1][j] : w0[j]) + d);
        end
      end
      for (int j = 0; j < N; j++) w0[j] = wa[NS-1][j];
      ep++;
      if (mx < th) begin ec = 1'b1; break; end
      if (ep == MAXP) break;
    end
    for (int j = 0; j < N; j++) ew[j] = w0[j];
    for (int k = 0; k < NS; k++) yq.push_back(dotsat(w0, k));
  endtask

  // output stream compared on every clock
  always @(negedge clk) begin
    if (!rst && y_valid) begin
      if (yq.size() == 0) check("R9 output beyond sample count", 1, 0);
      else check("R4/R9 separated output", longint'($signed(y_data)), longint'(yq.pop_front()));
    end
  end

  task automatic load_all();
    for (int k = 0; k < NS; k++) begin
      @(negedge clk);
      smp_we = 1'b1;
      smp_addr = AW'(k);
      for (int j = 0; j < N; j++) smp_data[j*DW +: DW] = DW'(smem[k][j]);
    end
    @(negedge clk);
    smp_we = 1'b0;
  endtask

  task automatic run(input int th, input bit poke);
    int ep;
    bit ec;
    int ew [N];
    int cyc;
    model(th, ep, ec, ew);
    @(negedge clk);
    conv_thresh = DW'(th);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R3 busy after start", busy, 1);
    check("R3 done cleared", done, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      smp_we = 1'b1;
      smp_addr = '0;
      smp_data = {4{16'h1234}};
      start = 1'b1;
      @(negedge clk);
      smp_we = 1'b0;
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    check("R9 run finished", done, 1);
    check("R8 completed passes", passes, ep);
    check("R7 convergence flag", conv_ok, ec);
    check("R9 busy low at end", busy, 0);
    check("R9 all outputs seen", yq.size(), 0);
    for (int j = 0; j < N; j++)
      check("R2/R5/R6 learned weight", longint'($signed(wgt_o[j*DW +: DW])), ew[j]);
    repeat (4) @(negedge clk);
    for (int j = 0; j < N; j++)
      check("R10 weight held while idle", longint'($signed(wgt_o[j*DW +: DW])), ew[j]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s1 [NS];
    int s2 [NS];
    s1 = '{1, -1, 1, -1, 1, 1, -1, -1};
    s2 = '{1, 1, -1, -1, 1, -1, 1, -1};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 conv_ok", conv_ok, 0);
    check("R1 y_valid", y_valid, 0);
    check("R1 passes", passes, 0);
    for (int j = 0; j < N; j++)
      check("R1 identity row", longint'($signed(wgt_o[j*DW +: DW])), (j == ROW) ? 16384 : 0);

    // two sources through a 2x2 mixing matrix
    for (int k = 0; k < NS; k++) begin
      smem[k][0] = 6000 * s1[k] + (5000 * s2[k]) / 2;
      smem[k][1] = (6000 * s1[k]) / 4 + 5000 * s2[k];
      smem[k][2] = 0;
      smem[k][3] = 0;
    end
    load_all();
    run(32767, 1'b0);   // R7: met after the first pass
    run(0, 1'b1);       // R8 forced exit; R2/R3 write and start during the run
    run(1200, 1'b0);    // R7 with an intermediate threshold
    run(32767, 1'b0);   // R2: stored sample 0 still intact

    // large values on all lanes: saturation paths
    for (int k = 0; k < NS; k++)
      for (int j = 0; j < N; j++) begin
        smem[k][j] = (((k * 7 + j * 3) % 11) - 5) * 6000;
        if (smem[k][j] > 30000) smem[k][j] = 30000;
      end
    load_all();
    run(0, 1'b0);
    run(32767, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule